// File: doc/BRIEF.md
# Center-Spread Triangle Profile Generator

This block produces the digital frequency-offset profile for a spread-spectrum clock modulator that spreads symmetrically about its reference. It runs on the reference clock. Every cycle it presents a signed deviation word, in steps of 0.125 %, which a downstream divider or digitally controlled oscillator turns into a frequency sweep between reference × (1 − d) and reference × (1 + d). The sweep is a linear triangle. It starts at zero, climbs to +peak, falls through zero to −peak and comes back to zero once per modulation period.

Four static select pins control the profile. A rate pin chooses the period length, 1152 or 1920 reference cycles. Two range pins, together with the rate pin, choose the peak deviation. An active-low enable turns spreading on. The pins pass through a synchronizer. A new setting is adopted only at a period boundary, where the offset is zero, so the output never jumps. A fractional phase accumulator spreads the deviation steps evenly, so each peak is reached exactly at the quarter points. Two of the eight codes are reserved and behave as "spread off".

Top module: `sscg_tri_mod`

## Requirements
- R1: After synchronous reset, `offset` is 0, `active` is 0 and `period_start` is 0.
- R2: With code {rate_sel, range_sel1, range_sel0}, the peak K in units of 0.125 % is 000→9, 001→14, 010→6, 011→10, 100→10 and 101→16.
- R3: One modulation period lasts 1152 cycles when rate_sel=0 and 1920 cycles when rate_sel=1.
- R4: Let P be the period, Q=P/4 and n the phase (0 at a period start). Define t=n for n≤Q, t=2Q−n for Q<n≤3Q, and t=n−4Q otherwise. Then `offset` equals sign(t)·floor(K·|t|/Q).
- R5: While the synchronized spread_off_n is 1, `offset` is 0 and `active` is 0 from the next period boundary onward.
- R6: Codes 110 and 111 are reserved. They give `offset` 0, `active` 0 and no `period_start` pulses.
- R7: `period_start` is high for exactly the one cycle in which n=0. `active` is high throughout every running period.
- R8: A change on any select pin, or on spread_off_n, is ignored until the current period ends. When the block is idle, a valid enabled setting starts a period, with `period_start` high, 3 cycles after the pins change.
- R9: `offset` changes by at most one step between consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 1 | Period select: 0 short, 1 long |
| range_sel1 | input | 1 | Range select, upper bit |
| range_sel0 | input | 1 | Range select, lower bit |
| spread_off_n | input | 1 | Spread disable when 1, enable when 0 |
| offset | output | 6 | Signed deviation word, 0.125 % per step |
| active | output | 1 | Profile running |
| period_start | output | 1 | One-cycle pulse at the start of each period |

## Verification
Each of the six valid codes is run for two whole periods and compared cycle by cycle against the arithmetic triangle. This separates the peak decoding, the two period lengths, the rounding of the fractional accumulator and the pulse spacing. The two reserved codes and a disabled enable are each held for many cycles to show a zero offset with no activity. A pin change in the middle of a period, both to another code and to disable, shows that the old profile runs to the boundary and the new setting takes over only afterwards.

// File: rtl/sscg_pkg.sv
package sscg_pkg;

    localparam int OFF_W  = 6;
    localparam int PEAK_W = 5;

    typedef logic [PEAK_W-1:0] peak_t;

    function automatic peak_t peak_of(input logic [2:0] code);
        case (code)
            3'b000:  peak_of = peak_t'(9);
            3'b001:  peak_of = peak_t'(14);
            3'b010:  peak_of = peak_t'(6);
            3'b011:  peak_of = peak_t'(10);
            3'b100:  peak_of = peak_t'(10);
            3'b101:  peak_of = peak_t'(16);
            default: peak_of = peak_t'(0);
        endcase
    endfunction

endpackage

// File: rtl/sscg_sync.sv
module sscg_sync #(
    parameter int          W        = 4,
    parameter int          STAGES   = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         stage_q[s] <= RST_VAL;
                else if (s == 0) stage_q[s] <= din;
                else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sscg_decode.sv
module sscg_decode
    import sscg_pkg::*;
(
    input  logic [2:0] code,
    input  logic       off_n,
    output logic       en,
    output logic       slow,
    output peak_t      peak
);
    always_comb begin
        slow = code[2];
        peak = peak_of(code);
        en   = !off_n && (code[2:1] != 2'b11);
    end
endmodule

// File: rtl/sscg_profile.sv
module sscg_profile
    import sscg_pkg::*;
#(
    parameter int PER_FAST = 1152,
    parameter int PER_SLOW = 1920
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_slow,
    input  peak_t            cfg_peak,
    output logic [OFF_W-1:0] offset,
    output logic             active,
    output logic             period_start
);
    localparam int PER_MAX = (PER_SLOW > PER_FAST) ? PER_SLOW : PER_FAST;
    localparam int CNT_W   = $clog2(PER_MAX);
    localparam int RW      = CNT_W + 1;
    localparam logic [RW-1:0] QF = RW'(PER_FAST / 4);
    localparam logic [RW-1:0] QS = RW'(PER_SLOW / 4);

    typedef struct packed {
        logic             run;
        logic             slow;
        peak_t            peak;
        logic [RW-1:0]    n;
        logic [PEAK_W-1:0] mag;
        logic [RW-1:0]    rem;
        logic [OFF_W-1:0] off;
        logic             pulse;
    } state_t;

    state_t st_d, st_q;

    logic [RW-1:0] qlen, plen, kext, sum;
    logic          bnd, grow, neg;

    always_comb begin
        st_d = st_q;
        qlen = st_q.slow ? QS : QF;
        plen = qlen << 2;
        kext = RW'(st_q.peak);
        bnd  = !st_q.run || (st_q.n == plen - 1'b1);
        grow = (st_q.n < qlen) || ((st_q.n >= (qlen << 1)) && (st_q.n < (qlen * 3)));
        sum  = st_q.rem + kext;
        neg  = 1'b0;

        if (bnd) begin
            st_d.run  = cfg_en;
            st_d.slow = cfg_slow;
            st_d.peak = cfg_en ? cfg_peak : '0;
            st_d.n    = '0;
            st_d.mag  = '0;
            st_d.rem  = '0;
        end else begin
            st_d.n = st_q.n + 1'b1;
            if (grow) begin
                if (sum >= qlen) begin
                    st_d.rem = sum - qlen;
                    st_d.mag = st_q.mag + 1'b1;
                end else begin
                    st_d.rem = sum;
                end
            end else begin
                if (st_q.rem >= kext) begin
                    st_d.rem = st_q.rem - kext;
                end else begin
                    st_d.rem = st_q.rem + qlen - kext;
                    st_d.mag = st_q.mag - 1'b1;
                end
            end
            neg = st_d.n > (qlen << 1);
        end

        st_d.off   = neg ? OFF_W'(-$signed({1'b0, st_d.mag}))
                         : OFF_W'({1'b0, st_d.mag});
        st_d.pulse = bnd && cfg_en;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign offset       = st_q.off;
    assign active       = st_q.run;
    assign period_start = st_q.pulse;

    a_r5_zero_when_idle: assert property (@(posedge clk) disable iff (rst)
        !st_q.run |-> (st_q.off == '0));

    a_r7_pulse_at_phase0: assert property (@(posedge clk) disable iff (rst)
        st_q.pulse |-> (st_q.run && st_q.n == '0));

    a_r9_unit_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((st_q.off == $past(st_q.off)) ||
                  (st_q.off == $past(st_q.off) + 1'b1) ||
                  (st_q.off == $past(st_q.off) - 1'b1)));

    a_r2_peak_bound: assert property (@(posedge clk) disable iff (rst)
        ($signed(st_q.off) <= $signed({1'b0, st_q.peak})) &&
        ($signed(st_q.off) >= -$signed({1'b0, st_q.peak})));

    a_r8_cfg_held: assert property (@(posedge clk) disable iff (rst)
        (st_q.run && st_q.n != '0) |-> ($stable(st_q.peak) && $stable(st_q.slow)));

    a_r4_zero_at_half: assert property (@(posedge clk) disable iff (rst)
        (st_q.run && st_q.n == (qlen << 1)) |-> (st_q.off == '0));
endmodule

// File: rtl/sscg_tri_mod.sv
module sscg_tri_mod
    import sscg_pkg::*;
#(
    parameter int PER_FAST    = 1152,
    parameter int PER_SLOW    = 1920,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rate_sel,
    input  logic             range_sel1,
    input  logic             range_sel0,
    input  logic             spread_off_n,
    output logic [OFF_W-1:0] offset,
    output logic             active,
    output logic             period_start
);
    logic [3:0] pins_s;
    logic       cfg_en, cfg_slow;
    peak_t      cfg_peak;

    sscg_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1111)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({rate_sel, range_sel1, range_sel0, spread_off_n}),
        .dout (pins_s)
    );

    sscg_decode i_decode (
        .code  (pins_s[3:1]),
        .off_n (pins_s[0]),
        .en    (cfg_en),
        .slow  (cfg_slow),
        .peak  (cfg_peak)
    );

    sscg_profile #(.PER_FAST(PER_FAST), .PER_SLOW(PER_SLOW)) i_profile (
        .clk          (clk),
        .rst          (rst),
        .cfg_en       (cfg_en),
        .cfg_slow     (cfg_slow),
        .cfg_peak     (cfg_peak),
        .offset       (offset),
        .active       (active),
        .period_start (period_start)
    );
endmodule

// File: tb/test_sscg_tri_mod.sv
module test_sscg_tri_mod;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rate_sel = 1'b1, range_sel1 = 1'b1, range_sel0 = 1'b1, spread_off_n = 1'b1;
    logic [5:0] offset;
    logic active, period_start;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sscg_tri_mod i_sscg_tri_mod (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .range_sel1(range_sel1),
        .range_sel0(range_sel0), .spread_off_n(spread_off_n),
        .offset(offset), .active(active), .period_start(period_start)
    );

    function automatic int peak_k(input int c);
        case (c)
            0: return 9;  1: return 14; 2: return 6;
            3: return 10; 4: return 10; 5: return 16;
            default: return 0;
        endcase
    endfunction

    function automatic int per_of(input int c);
        return (c >= 4) ? 1920 : 1152;
    endfunction

    function automatic int model(input int n, input int k, input int p);
        int q, t, m;
        q = p / 4;
        if (n <= q)          t = n;
        else if (n <= 3 * q) t = 2 * q - n;
        else                 t = n - 4 * q;
        m = (k * (t < 0 ? -t : t)) / q;
        return (t < 0) ? -m : m;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_pins(input int c, input logic off_n);
        rate_sel     = c[2];
        range_sel1   = c[1];
        range_sel0   = c[0];
        spread_off_n = off_n;
    endtask

    task automatic go_idle();
        int w = 0;
        set_pins(7, 1'b1);
        while (active && w < 5000) begin @(negedge clk); w++; end
        check(!active, "R5 idle reached", active, 0);
    endtask

    task automatic start(input int c);
        int w = 0;
        go_idle();
        set_pins(c, 1'b0);
        @(negedge clk); w++;
        while (!period_start && w < 20) begin @(negedge clk); w++; end
        check(w == 3, "R8 start latency", w, 3);
    endtask

    // Checks one full period from n=0; optionally changes pins at phase 100.
    task automatic run_period(input int c, input bit chg, input int nc, input logic noff);
        int k = peak_k(c);
        int p = per_of(c);
        int prev = 0;
        for (int n = 0; n < p; n++) begin
            int e = model(n, k, p);
            int a = $signed(offset);
            check(a == e, $sformatf("R4 code%0d n%0d", c, n), a, e);
            check(period_start == (n == 0), "R7 pulse", period_start, n == 0);
            check(active == 1'b1, "R7 active", active, 1);
            if (n > 0) check(a - prev <= 1 && prev - a <= 1, "R9 step", a, prev);
            if (n == p / 4) check(a == k, "R2 peak", a, k);
            prev = a;
            if (chg && n == 100) set_pins(nc, noff);
            @(negedge clk);
        end
    endtask

    task automatic check_quiet(input string tag, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            check(offset == 6'd0 && !active && !period_start, tag,
                  {active, period_start, offset}, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(offset == 0 && !active && !period_start, "R1 reset state",
              {active, period_start, offset}, 0);
        // R3: each valid code, two periods; the second pulse marks the period length
        for (int c = 0; c < 6; c++) begin
            start(c);
            run_period(c, 1'b0, 0, 1'b0);
            check(period_start == 1'b1, "R3 period length", period_start, 1);
            run_period(c, 1'b0, 0, 1'b0);
        end
        // R8: mid-period switch from code 0 to code 5
        start(0);
        run_period(0, 1'b1, 5, 1'b0);
        run_period(5, 1'b0, 0, 1'b0);
        // R5/R8: disable mid-period, profile finishes first
        run_period(5, 1'b1, 5, 1'b1);
        check_quiet("R5 disabled quiet", 200);
        // R6: reserved codes
        for (int c = 6; c < 8; c++) begin
            set_pins(c, 1'b0);
            repeat (5) @(negedge clk);
            check_quiet($sformatf("R6 reserved code%0d", c), 300);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule